// File: doc/BRIEF.md
# Interleaved Multichannel Median Filter

This block cleans impulsive noise from sixteen digitised signals that share one sample stream. Samples arrive round-robin, one channel per accepted slot, so each channel advances at one sixteenth of the stream rate. A single median engine serves every channel in turn. It keeps a separate circular history for each channel and outputs, for every accepted sample, the median of that channel's most recent samples. The result carries the index of the channel it belongs to.

A marker input flags the slot that carries channel zero. Between markers the channel index steps by one for each accepted sample. The window length is a runtime setting of up to 15 points, and only odd lengths take effect. A change of the effective length discards all stored history, so every channel starts again. While a channel is still filling its window, the median is taken over the samples it has so far. Output order equals input order, and every result appears after a fixed delay.

Top module: `imf_top`

## Requirements
- R1: An accepted sample (in_valid=1) with in_first=1 belongs to channel 0. Any other accepted sample belongs to the previous accepted sample's channel plus one, wrapping from 15 to 0. The channel travels with the result on out_chan. Cycles with in_valid=0 do not advance the channel.
- R2: Each accepted sample produces exactly one result with out_valid=1, two clock cycles after the edge that accepts it. Results leave in the order the samples arrived.
- R3: The result is the sample of ascending rank floor((n-1)/2), counting from 0, among the n most recent samples of that channel, including the current one. Here n = min(L, k), L is the effective length and k is the number of samples the channel has received since the last clear.
- R4: The effective length L is derived from cfg_taps (4 bits) as follows. An odd value is used as is. An even value from 2 to 14 is reduced by one. A value of 0 gives 1.
- R5: With L=1 every result equals its input sample.
- R6: A channel's results depend only on that channel's own samples.
- R7: When L changes, all channel histories are cleared. A sample accepted in the same cycle as the change is the first sample of its channel's new history, so its result equals the sample itself. A change of cfg_taps that leaves L unchanged clears nothing.
- R8: While rst is high, out_valid is low. After reset every history is empty and the next accepted sample is channel 0, whatever in_first is.
- R9: A cycle with in_valid=0 stores nothing and produces no result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Sample present in this cycle |
| in_first | input | 1 | Current sample belongs to channel 0 |
| in_data | input | 10 | Input sample |
| cfg_taps | input | 4 | Requested window length |
| out_valid | output | 1 | Result present |
| out_data | output | 10 | Filtered sample |
| out_chan | output | 4 | Channel of the result |

## Verification
Two events can fall in the same cycle: a change of the effective length, which clears all histories, and the write of a new sample into one of those histories. The bench changes cfg_taps in the very cycle it presents a sample, in the middle of a frame. It expects that sample's result to be the sample itself, and it expects the following channels to restart from empty windows. A second case changes cfg_taps from 5 to 6, which leaves L unchanged, so no history may be lost. A reference model keeps its own per-channel histories, sorts each window, and judges every result's value, channel and arrival cycle.

// File: rtl/imf_pkg.sv
package imf_pkg;
  localparam int SAMPLE_W   = 10;
  localparam int CHANNELS   = 16;
  localparam int HIST_DEPTH = 16;
  localparam int MAX_TAPS   = 15;

  // Odd window length taken from a raw request (even rounds down, 0 -> 1)
  function automatic int odd_taps(input int req);
    if (req <= 1) return 1;
    if ((req % 2) == 0) return req - 1;
    return req;
  endfunction
endpackage

// File: rtl/imf_chan_seq.sv
module imf_chan_seq #(
  parameter int NCH = 16,
  localparam int CW = $clog2(NCH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          valid,
  input  logic          first,
  output logic [CW-1:0] chan
);
  logic [CW-1:0] next_q;

  assign chan = first ? '0 : next_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      next_q <= '0;
    end else if (valid) begin
      next_q <= (chan == CW'(NCH - 1)) ? '0 : chan + 1'b1;
    end
  end
endmodule

// File: rtl/imf_history.sv
module imf_history #(
  parameter int DW    = 10,
  parameter int NCH   = 16,
  parameter int DEPTH = 16,
  parameter int TAPS  = 15,
  localparam int CW = $clog2(NCH),
  localparam int PW = $clog2(DEPTH),
  localparam int LW = $clog2(TAPS + 1)
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_en,
  input  logic [CW-1:0]             chan,
  input  logic [DW-1:0]             din,
  input  logic [LW-1:0]             taps,
  input  logic                      clear,
  output logic [TAPS-1:0][DW-1:0]   win_q,
  output logic [LW-1:0]             cnt_q
);
  localparam int MEM_N = (1 << CW) * DEPTH;

  logic [DW-1:0] mem [MEM_N];
  logic [PW-1:0] wptr [NCH];
  logic [LW-1:0] fill [NCH];

  logic [LW-1:0]           fill_cur, fill_nxt, n_d;
  logic [LW:0]             avail;
  logic [PW-1:0]           ptr_cur;
  logic [TAPS-1:0][DW-1:0] win_d;

  assign ptr_cur  = wptr[chan];
  assign fill_cur = clear ? '0 : fill[chan];
  assign fill_nxt = (fill_cur == LW'(TAPS)) ? fill_cur : fill_cur + 1'b1;
  assign avail    = {1'b0, fill_cur} + 1'b1;
  assign n_d      = (avail > {1'b0, taps}) ? taps : avail[LW-1:0];

  // Slot 0 is the arriving sample, slot k the k-th older one
  assign win_d[0] = din;
  generate
    for (genvar k = 1; k < TAPS; k++) begin : g_slot
      assign win_d[k] = mem[{chan, ptr_cur - PW'(k)}];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (wr_en) begin
      mem[{chan, ptr_cur}] <= din;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < NCH; c++) begin
        wptr[c] <= '0;
        fill[c] <= '0;
      end
    end else begin
      if (clear) begin
        for (int c = 0; c < NCH; c++) begin
          fill[c] <= '0;
        end
      end
      if (wr_en) begin
        wptr[chan] <= ptr_cur + 1'b1;
        fill[chan] <= fill_nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) begin
      win_q <= win_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= LW'(1);
    end else if (wr_en) begin
      cnt_q <= n_d;
    end
  end
endmodule

// File: rtl/imf_rank_sel.sv
module imf_rank_sel #(
  parameter int DW   = 10,
  parameter int TAPS = 15,
  localparam int LW = $clog2(TAPS + 1)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic [TAPS-1:0][DW-1:0] win,
  input  logic [LW-1:0]           cnt,
  output logic [DW-1:0]           med_q
);
  logic [LW-1:0]   target;
  logic [TAPS-1:0] hit;
  logic [DW-1:0]   med_d;

  assign target = (cnt - 1'b1) >> 1;

  // Unique rank per live slot; ties broken by slot index
  generate
    for (genvar i = 0; i < TAPS; i++) begin : g_cand
      logic [LW-1:0] rank;
      always_comb begin
        rank = '0;
        for (int j = 0; j < TAPS; j++) begin
          if ((LW'(j) < cnt) &&
              ((win[j] < win[i]) || ((win[j] == win[i]) && (j < i)))) begin
            rank = rank + 1'b1;
          end
        end
      end
      assign hit[i] = (LW'(i) < cnt) && (rank == target);
    end
  endgenerate

  always_comb begin
    med_d = '0;
    for (int i = 0; i < TAPS; i++) begin
      if (hit[i]) med_d = med_d | win[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      med_q <= '0;
    end else if (en) begin
      med_q <= med_d;
    end
  end
endmodule

// File: rtl/imf_top.sv
module imf_top
  import imf_pkg::*;
#(
  parameter int DW    = SAMPLE_W,
  parameter int NCH   = CHANNELS,
  parameter int DEPTH = HIST_DEPTH,
  parameter int TAPS  = MAX_TAPS,
  localparam int CW = $clog2(NCH),
  localparam int LW = $clog2(TAPS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  input  logic          in_first,
  input  logic [DW-1:0] in_data,
  input  logic [LW-1:0] cfg_taps,
  output logic          out_valid,
  output logic [DW-1:0] out_data,
  output logic [CW-1:0] out_chan
);
  logic [CW-1:0]           chan;
  logic [LW-1:0]           taps_eff, taps_prev_q;
  logic                    clear;
  logic [TAPS-1:0][DW-1:0] win_q;
  logic [LW-1:0]           cnt_q;
  logic                    v1_q;
  logic [CW-1:0]           c1_q;

  assign taps_eff = LW'(odd_taps(int'(cfg_taps)));
  assign clear    = (taps_eff != taps_prev_q);

  always_ff @(posedge clk) begin
    if (rst) taps_prev_q <= LW'(1);
    else     taps_prev_q <= taps_eff;
  end

  imf_chan_seq #(.NCH(NCH)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .valid(in_valid),
    .first(in_first),
    .chan (chan)
  );

  imf_history #(.DW(DW), .NCH(NCH), .DEPTH(DEPTH), .TAPS(TAPS)) u_hist (
    .clk  (clk),
    .rst  (rst),
    .wr_en(in_valid),
    .chan (chan),
    .din  (in_data),
    .taps (taps_eff),
    .clear(clear),
    .win_q(win_q),
    .cnt_q(cnt_q)
  );

  imf_rank_sel #(.DW(DW), .TAPS(TAPS)) u_sel (
    .clk  (clk),
    .rst  (rst),
    .en   (v1_q),
    .win  (win_q),
    .cnt  (cnt_q),
    .med_q(out_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      v1_q      <= 1'b0;
      c1_q      <= '0;
      out_valid <= 1'b0;
      out_chan  <= '0;
    end else begin
      v1_q      <= in_valid;
      out_valid <= v1_q;
      if (in_valid) c1_q <= chan;
      if (v1_q) out_chan <= c1_q;
    end
  end
endmodule

// File: rtl/imf_chk.sv
module imf_chk #(
  parameter int DW = 10,
  parameter int CW = 4,
  parameter int LW = 4
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          in_first,
  input logic [DW-1:0] in_data,
  input logic [LW-1:0] cfg_taps,
  input logic          out_valid,
  input logic [DW-1:0] out_data,
  input logic [CW-1:0] out_chan
);
  logic [1:0] age;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (age != 2'd3) age <= age + 1'b1;
  end

  // R2
  out_latency_chk: assert property (@(posedge clk) disable iff (rst)
    (age == 2'd3) |-> (out_valid == $past(in_valid, 2)));

  // R1
  first_chan_zero_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first) |-> ##2 (out_valid && (out_chan == '0)));

  // R5
  single_tap_pass_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && (cfg_taps <= LW'(1))) |-> ##2 (out_data == $past(in_data, 2)));

  // R7
  change_restart_chk: assert property (@(posedge clk) disable iff (rst)
    ((age != 2'd0) && in_valid && cfg_taps[0] && $past(cfg_taps[0]) &&
     (cfg_taps != $past(cfg_taps))) |-> ##2 (out_data == $past(in_data, 2)));

  // R9
  idle_silent_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid) |-> ##2 (!out_valid));

  // R8
  reset_quiet_chk: assert property (@(posedge clk)
    rst |=> !out_valid);
endmodule

bind imf_top imf_chk #(.DW(DW), .CW(CW), .LW(LW)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .in_valid (in_valid),
  .in_first (in_first),
  .in_data  (in_data),
  .cfg_taps (cfg_taps),
  .out_valid(out_valid),
  .out_data (out_data),
  .out_chan (out_chan)
);

// File: tb/tb_imf_top.sv
module tb_imf_top;
  localparam int NCH = 16;
  localparam int HMAX = 15;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic       in_first = 1'b0;
  logic [9:0] in_data = '0;
  logic [3:0] cfg_taps = 4'd1;
  logic       out_valid;
  logic [9:0] out_data;
  logic [3:0] out_chan;

  always #5 clk = ~clk;

  imf_top dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_first(in_first),
    .in_data(in_data), .cfg_taps(cfg_taps), .out_valid(out_valid),
    .out_data(out_data), .out_chan(out_chan)
  );

  typedef struct {
    int    due;
    int    ch;
    int    val;
    string req;
  } exp_t;

  exp_t  sb[$];
  int    hist[NCH][$];
  int    m_ch = 0;
  int    m_prev = -1;
  int    cur_taps = 1;
  string cur_req = "R3";
  int    cyc = 0;
  int    checks = 0;
  int    errors = 0;

  always @(posedge clk) cyc++;

  // R4: effective length from the requested one
  function automatic int eff_len(input int t);
    if (t <= 1) return 1;
    if ((t % 2) == 0) return t - 1;
    return t;
  endfunction

  task automatic model_len();
    int e;
    e = eff_len(cur_taps);
    if (e != m_prev) begin
      for (int c = 0; c < NCH; c++) hist[c].delete();
      m_prev = e;
    end
  endtask

  task automatic send(input int d, input bit f);
    int   ch, n, e;
    int   w[$];
    exp_t x;
    @(negedge clk);
    in_valid = 1'b1;
    in_data  = 10'(d);
    in_first = f;
    cfg_taps = 4'(cur_taps);
    model_len();
    e  = eff_len(cur_taps);
    ch = f ? 0 : m_ch;
    m_ch = (ch + 1) % NCH;
    hist[ch].push_front(d);
    if (hist[ch].size() > HMAX) void'(hist[ch].pop_back());
    n = (e < hist[ch].size()) ? e : hist[ch].size();
    w.delete();
    for (int i = 0; i < n; i++) w.push_back(hist[ch][i]);
    w.sort();
    x.due = cyc + 2;
    x.ch  = ch;
    x.val = w[(n - 1) / 2];
    x.req = cur_req;
    sb.push_back(x);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_valid = 1'b0;
      in_first = 1'b0;
      cfg_taps = 4'(cur_taps);
      model_len();
    end
  endtask

  task automatic frame(input int n, input int lo, input int hi);
    for (int i = 0; i < n; i++) begin
      send(lo + int'($urandom % 32'(hi - lo + 1)), i == 0);
    end
  endtask

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Scoreboard monitor
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      checks++;
      if (sb.size() == 0) begin
        errors++;
        $display("FAIL R9: unexpected result ch %0d data %0d, expected none", out_chan, out_data);
      end else begin
        exp_t x;
        x = sb.pop_front();
        if (x.due != cyc || int'(out_chan) != x.ch || int'(out_data) != x.val) begin
          errors++;
          $display("FAIL %s: cyc %0d ch %0d data %0d, expected cyc %0d ch %0d data %0d",
                   x.req, cyc, out_chan, out_data, x.due, x.ch, x.val);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, actual timeout expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    // R8: quiet during reset
    repeat (4) @(posedge clk);
    #1 chk(out_valid == 1'b0, "R8 reset", int'(out_valid), 0);
    @(negedge clk);
    rst = 1'b0;
    idle(2);

    // R5: single tap passes data
    cur_req = "R5"; cur_taps = 1;
    frame(16, 0, 1023);
    frame(8, 0, 1023);

    // R3: five taps, fill-up then steady
    cur_req = "R3"; cur_taps = 5; idle(1);
    for (int f = 0; f < 4; f++) frame(16, 0, 1023);

    // R4: 6 keeps L=5 (no clear), then 0 gives 1
    cur_req = "R4"; cur_taps = 6;
    frame(16, 0, 1023);
    cur_taps = 0;
    frame(16, 0, 1023);

    // R6: channel 3 constant, others wild
    cur_req = "R6"; cur_taps = 3; idle(1);
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < NCH; i++) begin
        send((i == 3) ? 100 : int'($urandom % 1024), i == 0);
      end
    end

    // R3: longest window, includes duplicates and extremes
    cur_req = "R3"; cur_taps = 15; idle(1);
    for (int f = 0; f < 18; f++) frame(16, 0, 3);
    for (int f = 0; f < 4; f++) begin
      for (int i = 0; i < NCH; i++) send(((f + i) % 2 == 0) ? 0 : 1023, i == 0);
    end

    // R7: length change in the same cycle as a sample, mid-frame
    cur_req = "R7"; cur_taps = 9;
    for (int i = 0; i < 7; i++) send(int'($urandom % 1024), i == 0);
    cur_taps = 7;
    for (int i = 7; i < NCH; i++) send(int'($urandom % 1024), 1'b0);
    frame(16, 0, 1023);
    cur_taps = 3; idle(2);
    frame(16, 0, 1023);

    // R9: gaps between samples
    cur_req = "R9"; cur_taps = 7;
    for (int f = 0; f < 3; f++) begin
      for (int i = 0; i < NCH; i++) begin
        send(int'($urandom % 1024), i == 0);
        idle(i % 3);
      end
    end

    // R1: early re-sync after seven channels
    cur_req = "R1"; cur_taps = 5;
    for (int i = 0; i < 7; i++) send(int'($urandom % 1024), i == 0);
    frame(16, 0, 1023);
    for (int i = 0; i < 20; i++) send(int'($urandom % 1024), 1'b0);

    // R8: reset mid-run, histories and channel counter restart
    idle(4);
    chk(sb.size() == 0, "R2 drained", sb.size(), 0);
    @(negedge clk); rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c < NCH; c++) hist[c].delete();
    m_ch = 0; m_prev = -1;
    cur_req = "R8";
    for (int i = 0; i < 24; i++) send(int'($urandom % 1024), 1'b0);

    idle(5);
    chk(sb.size() == 0, "R2 all results seen", sb.size(), 0);
    chk(out_valid == 1'b0, "R9 idle output", int'(out_valid), 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule